// File: doc/BRIEF.md
# Four-Lane 7:1 Deserializer with Bit Remapping

This block rebuilds a 28-bit parallel word from four serial data lanes that each carry seven bits per word period. Everything runs on one clock at the serial bit rate. A fifth input carries the slow forwarded clock, and the block samples it like a data lane at the bit rate. The last seven samples of that lane mark where a word begins and ends. Each data lane feeds a 7-bit shift register. When a word boundary is confirmed, the four registers are steered into fixed, interleaved positions of the output word. The output word register loads on the next clock, and a one-cycle valid pulse goes with it.

The lanes do not carry contiguous bit fields. The bits are interleaved, and the most significant bit of the word travels last on lane 3. The block stays silent until it has seen two framing patterns exactly seven bits apart. It drops lock and searches again as soon as a predicted boundary lacks the pattern. An active-low clear input forces every register and output to zero while it is held low.

Top module: `quad_lane_deser7`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `word_out` is 0, `word_vld` is 0 and `locked` is 0.
- R2: Lane bits map to output bits by time order, with the first-arriving bit listed first. Lane 0 carries 7,6,4,3,2,1,0. Lane 1 carries 18,15,14,13,12,9,8. Lane 2 carries 26,25,24,22,21,20,19. Lane 3 carries 23,17,16,11,10,5,27. Each output word is reproduced bit-exactly.
- R3: A word boundary exists only when the last seven samples of `fclk_in` are 1,1,0,0,0,1,1, oldest first. With any other repeating clock-lane pattern (for example 1010101 or 1100001), `word_vld` and `locked` stay 0.
- R4: `locked` rises, and the first `word_vld` appears, only at a boundary that lies exactly seven bit clocks after the previous one. The word at that second boundary is the first word delivered, and `word_vld` is never high while `locked` is low. Boundaries spaced any other distance apart do not lock.
- R5: Let a word's seventh bit be sampled at clock edge E. Then `word_out` and a one-cycle `word_vld` update at edge E+1. Between pulses, `word_out` holds its value.
- R6: While locked, if the pattern is missing at a predicted boundary, no `word_vld` is produced for that word and `locked` falls one clock later. Two fresh boundaries seven bits apart are then needed before the next word is delivered.
- R7: While `clear_n` is low, every register clears to zero: `word_out`, `word_vld`, `locked`, the lane shift registers and the framing state. A word whose load edge falls inside the clear is lost. After release, a full two-boundary lock is needed again.
- R8: With back-to-back words on the lanes, one `word_vld` occurs every seven clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_n | input | 1 | Active-low shutdown/clear, synchronous |
| lane_in | input | 4 | One serial data bit per lane per clock |
| fclk_in | input | 1 | Sampled forwarded word clock |
| word_out | output | 28 | Rebuilt parallel word |
| word_vld | output | 1 | One-cycle pulse when `word_out` loads |
| locked | output | 1 | Framing confirmed |

## Verification
The hardest state to reach from the ports is a mis-spaced boundary pair: a valid framing pattern that arrives after the verify window has already closed. The stimulus reaches it by inserting three idle bit times between two framed words. The tracker then fails its check at distance seven, returns to search, and re-arms on the late pattern. A third word then confirms lock, so only that word appears. Loss of lock is reached by giving one word inside a locked stream a flat clock lane. Lane steering is proven by walking a single one through all 28 bit positions.

// File: rtl/qld_pkg.sv
package qld_pkg;

  typedef enum logic [1:0] {
    FR_SEARCH = 2'd0,
    FR_VERIFY = 2'd1,
    FR_LOCKED = 2'd2
  } frame_state_t;

  // Output bit index for lane 'lane', time slot 't' (0 = first to arrive).
  // The 4x7 geometry uses the interleaved map; other geometries fall back
  // to contiguous fields with the first bit landing in the field's MSB.
  function automatic int unsigned slot_target(int unsigned lane, int unsigned t,
                                              int unsigned lanes, int unsigned bits);
    int unsigned k;
    k = lane * 7 + t;
    if (lanes == 4 && bits == 7) begin
      case (k)
        0: return 7;   1: return 6;   2: return 4;   3: return 3;
        4: return 2;   5: return 1;   6: return 0;
        7: return 18;  8: return 15;  9: return 14;  10: return 13;
        11: return 12; 12: return 9;  13: return 8;
        14: return 26; 15: return 25; 16: return 24; 17: return 22;
        18: return 21; 19: return 20; 20: return 19;
        21: return 23; 22: return 17; 23: return 16; 24: return 11;
        25: return 10; 26: return 5;  default: return 27;
      endcase
    end
    return lane * bits + (bits - 1 - t);
  endfunction

endpackage

// File: rtl/qld_lane_shift.sv
module qld_lane_shift #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         kill,
  input  logic         din,
  output logic [W-1:0] q
);
  // q[W-1] holds the oldest sample, q[0] the newest.
  always_ff @(posedge clk) begin
    if (kill) q <= '0;
    else      q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/qld_frame_tracker.sv
module qld_frame_tracker
  import qld_pkg::*;
#(
  parameter int            BITS    = 7,
  parameter logic [BITS-1:0] PATTERN = 7'b1100011
) (
  input  logic            clk,
  input  logic            kill,
  input  logic [BITS-1:0] window,
  output logic            take,
  output logic            locked_o
);
  localparam int CNT_W = (BITS > 2) ? $clog2(BITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  frame_state_t       state_q, state_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               match, at_slot;

  assign match   = (window == PATTERN);
  assign at_slot = (cnt_q == LAST);

  always_comb begin
    state_n = state_q;
    take    = 1'b0;
    cnt_n   = at_slot ? '0 : cnt_q + 1'b1;
    case (state_q)
      FR_SEARCH: begin
        cnt_n = '0;
        if (match) state_n = FR_VERIFY;
      end
      FR_VERIFY, FR_LOCKED: begin
        if (at_slot) begin
          if (match) begin
            state_n = FR_LOCKED;
            take    = 1'b1;
          end else begin
            state_n = FR_SEARCH;
          end
        end
      end
      default: state_n = FR_SEARCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (kill) begin
      state_q  <= FR_SEARCH;
      cnt_q    <= '0;
      locked_o <= 1'b0;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      locked_o <= (state_n == FR_LOCKED);
    end
  end
endmodule

// File: rtl/qld_word_mapper.sv
module qld_word_mapper #(
  parameter int LANES = 4,
  parameter int BITS  = 7
) (
  input  logic [LANES*BITS-1:0] lanes_i,
  output logic [LANES*BITS-1:0] word_o
);
  // Pure wiring: lane l's window sits at lanes_i[l*BITS +: BITS], MSB oldest.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar t = 0; t < BITS; t++) begin : g_slot
      localparam int unsigned TGT = qld_pkg::slot_target(l, t, LANES, BITS);
      assign word_o[TGT] = lanes_i[l*BITS + (BITS-1-t)];
    end
  end
endmodule

// File: rtl/quad_lane_deser7.sv
module quad_lane_deser7 #(
  parameter int               LANES     = 4,
  parameter int               SLOT_BITS = 7,
  parameter logic [SLOT_BITS-1:0] FRAME_PAT = 7'b1100011
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear_n,
  input  logic [LANES-1:0]           lane_in,
  input  logic                       fclk_in,
  output logic [LANES*SLOT_BITS-1:0] word_out,
  output logic                       word_vld,
  output logic                       locked
);
  localparam int WORD_W = LANES * SLOT_BITS;

  logic                  kill;
  logic [WORD_W-1:0]     lane_win;
  logic [SLOT_BITS-1:0]  clk_win;
  logic [WORD_W-1:0]     mapped;
  logic                  take;

  assign kill = rst | ~clear_n;

  for (genvar l = 0; l < LANES; l++) begin : g_data
    qld_lane_shift #(.W(SLOT_BITS)) sh_i (
      .clk  (clk),
      .kill (kill),
      .din  (lane_in[l]),
      .q    (lane_win[l*SLOT_BITS +: SLOT_BITS])
    );
  end

  qld_lane_shift #(.W(SLOT_BITS)) clk_sh_i (
    .clk  (clk),
    .kill (kill),
    .din  (fclk_in),
    .q    (clk_win)
  );

  qld_frame_tracker #(.BITS(SLOT_BITS), .PATTERN(FRAME_PAT)) trk_i (
    .clk      (clk),
    .kill     (kill),
    .window   (clk_win),
    .take     (take),
    .locked_o (locked)
  );

  qld_word_mapper #(.LANES(LANES), .BITS(SLOT_BITS)) map_i (
    .lanes_i (lane_win),
    .word_o  (mapped)
  );

  always_ff @(posedge clk) begin
    if (kill) begin
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= take;
      if (take) word_out <= mapped;
    end
  end
endmodule

// File: rtl/quad_lane_deser7_chk.sv
module quad_lane_deser7_chk #(
  parameter int WORD_W = 28
) (
  input logic              clk,
  input logic              rst,
  input logic              clear_n,
  input logic [WORD_W-1:0] word_out,
  input logic              word_vld,
  input logic              locked
);
  logic [3:0] gap;

  always_ff @(posedge clk) begin
    if (rst || !clear_n) gap <= '0;
    else if (word_vld)   gap <= '0;
    else if (gap != 4'hF) gap <= gap + 4'd1;
  end

  assert_vld_needs_lock_R4: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> locked);

  assert_vld_single_R5: assert property (@(posedge clk) disable iff (rst || !clear_n)
    word_vld |=> !word_vld);

  assert_word_hold_R5: assert property (@(posedge clk) disable iff (rst || !clear_n)
    !word_vld |-> $stable(word_out));

  assert_word_spacing_R8: assert property (@(posedge clk) disable iff (rst || !clear_n)
    (word_vld && $past(locked)) |-> (gap == 4'd6));

  assert_loss_no_word_R6: assert property (@(posedge clk) disable iff (rst || !clear_n)
    $fell(locked) |-> !word_vld);

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !clear_n |=> (word_out == '0 && !word_vld && !locked));
endmodule

bind quad_lane_deser7 quad_lane_deser7_chk #(.WORD_W(LANES*SLOT_BITS)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .clear_n  (clear_n),
  .word_out (word_out),
  .word_vld (word_vld),
  .locked   (locked)
);

// File: tb/quad_lane_deser7_tb_top.sv
module quad_lane_deser7_tb_top;
  localparam logic [6:0] GOOD = 7'b1100011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clear_n = 1'b1;
  logic [3:0]  lane_in = '0;
  logic        fclk_in = 1'b0;
  logic [27:0] word_out;
  logic        word_vld;
  logic        locked;

  always #2 clk = ~clk;

  quad_lane_deser7 dut_i (
    .clk(clk), .rst(rst), .clear_n(clear_n), .lane_in(lane_in),
    .fclk_in(fclk_in), .word_out(word_out), .word_vld(word_vld), .locked(locked)
  );

  int checks = 0, fails = 0, cyc = 0, rx_n = 0;
  bit done = 1'b0;
  logic [27:0] rx_w [64];
  int          rx_c [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && word_vld) begin
      if (rx_n < 64) begin
        rx_w[rx_n] = word_out;
        rx_c[rx_n] = cyc;
      end
      rx_n++;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bidx(int l, int t);
    int m [4][7] = '{'{7,6,4,3,2,1,0}, '{18,15,14,13,12,9,8},
                     '{26,25,24,22,21,20,19}, '{23,17,16,11,10,5,27}};
    return m[l][t];
  endfunction

  task automatic send_word(logic [27:0] w, logic [6:0] pat);
    for (int t = 0; t < 7; t++) begin
      @(negedge clk);
      for (int l = 0; l < 4; l++) lane_in[l] = w[bidx(l, t)];
      fclk_in = pat[6-t];
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lane_in = '0;
      fclk_in = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; clear_n = 1'b1; lane_in = '0; fclk_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rx_n = 0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 word_out in reset", {4'h0, word_out}, 32'h0);
    check("R1 word_vld in reset", {31'h0, word_vld}, 32'h0);
    check("R1 locked in reset", {31'h0, locked}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 locked after reset", {31'h0, locked}, 32'h0);
    check("R1 word_out after reset", {4'h0, word_out}, 32'h0);
  endtask

  task automatic test_stream();
    logic [27:0] w [12];
    do_reset();
    for (int i = 0; i < 12; i++) w[i] = 28'($urandom());
    send_word(w[0], GOOD);
    idle(0);
    check("R4 no lock after one boundary", {31'h0, locked}, 32'h0);
    for (int i = 1; i < 12; i++) send_word(w[i], GOOD);
    idle(3);
    check("R4 words after lock", rx_n, 11);
    for (int i = 0; i < 11 && i < rx_n; i++) begin
      check("R2 random word bit-exact", {4'h0, rx_w[i]}, {4'h0, w[i+1]});
      if (i > 0) check("R8 seven-cycle spacing", rx_c[i] - rx_c[i-1], 7);
    end
  endtask

  task automatic test_walk();
    do_reset();
    send_word(28'h0, GOOD);
    for (int b = 0; b < 28; b++) send_word(28'h1 << b, GOOD);
    idle(3);
    check("R2 walking-one count", rx_n, 28);
    for (int b = 0; b < 28 && b < rx_n; b++)
      check("R2 walking-one position", {4'h0, rx_w[b]}, 32'h1 << b);
  endtask

  task automatic test_latency();
    logic [27:0] a, b, c;
    a = 28'h5A5A5A5; b = 28'hC3C3C3C; c = 28'h0F0F0F1;
    do_reset();
    send_word(a, GOOD);
    send_word(b, GOOD);
    send_word(c, GOOD);
    @(negedge clk); fclk_in = 1'b1; lane_in = '0;
    check("R5 no update at seventh-bit edge", {31'h0, word_vld}, 32'h0);
    check("R5 old word held", {4'h0, word_out}, {4'h0, b});
    @(negedge clk);
    check("R5 pulse one clock later", {31'h0, word_vld}, 32'h1);
    check("R5 new word loaded", {4'h0, word_out}, {4'h0, c});
    @(negedge clk);
    check("R5 pulse lasts one cycle", {31'h0, word_vld}, 32'h0);
    check("R5 word held after pulse", {4'h0, word_out}, {4'h0, c});
  endtask

  task automatic test_bad_pattern();
    do_reset();
    for (int i = 0; i < 6; i++) send_word(28'hFFFFFFF, 7'b1010101);
    for (int i = 0; i < 6; i++) send_word(28'h1234567, 7'b1100001);
    idle(3);
    check("R3 no word on wrong clock pattern", rx_n, 0);
    check("R3 no lock on wrong clock pattern", {31'h0, locked}, 32'h0);
  endtask

  task automatic test_spacing();
    logic [27:0] a, b, c;
    a = 28'h1111111; b = 28'h2222222; c = 28'h0ABCDEF;
    do_reset();
    send_word(a, GOOD);
    idle(3);
    send_word(b, GOOD);
    check("R4 no lock on ten-bit spacing", {31'h0, locked}, 32'h0);
    send_word(c, GOOD);
    idle(3);
    check("R4 only word after proper spacing", rx_n, 1);
    check("R4 delivered word", {4'h0, rx_w[0]}, {4'h0, c});
    check("R4 locked after proper spacing", {31'h0, locked}, 32'h1);
  endtask

  task automatic test_loss();
    logic [27:0] a, b, c, x, d, e;
    a = 28'h0000001; b = 28'h8000000; c = 28'h7654321;
    x = 28'hFFFFFFF; d = 28'h0C0FFEE; e = 28'h0BADF00;
    do_reset();
    send_word(a, GOOD); send_word(b, GOOD); send_word(c, GOOD);
    send_word(x, 7'b0000000);
    send_word(d, GOOD);
    check("R6 locked dropped after miss", {31'h0, locked}, 32'h0);
    check("R6 no word for missed frame", rx_n, 2);
    send_word(e, GOOD);
    idle(3);
    check("R6 relock word count", rx_n, 3);
    check("R6 words before miss", {4'h0, rx_w[1]}, {4'h0, c});
    check("R6 first word after relock", {4'h0, rx_w[2]}, {4'h0, e});
    check("R6 locked again", {31'h0, locked}, 32'h1);
  endtask

  task automatic test_clear();
    logic [27:0] a, b, c, d, e, f;
    a = 28'h1010101; b = 28'h2020202; c = 28'h3030303;
    d = 28'h4040404; e = 28'h5050505; f = 28'h6060606;
    do_reset();
    send_word(a, GOOD); send_word(b, GOOD); send_word(c, GOOD);
    @(negedge clk); clear_n = 1'b0;
    send_word(d, GOOD);
    check("R7 word_out cleared", {4'h0, word_out}, 32'h0);
    check("R7 locked cleared", {31'h0, locked}, 32'h0);
    check("R7 word_vld cleared", {31'h0, word_vld}, 32'h0);
    clear_n = 1'b1;
    send_word(e, GOOD);
    send_word(f, GOOD);
    idle(3);
    check("R7 word count across clear", rx_n, 2);
    check("R7 word before clear", {4'h0, rx_w[0]}, {4'h0, b});
    check("R7 first word after release", {4'h0, rx_w[1]}, {4'h0, f});
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    test_reset();
    test_stream();
    test_walk();
    test_latency();
    test_bad_pattern();
    test_spacing();
    test_loss();
    test_clear();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule